// File: doc/BRIEF.md
# Segment Register File with Descriptor Load

This block keeps the architectural and hidden state of a processor's segment registers. Each entry holds a 16-bit selector, a 64-bit base, a separately held effective base (the value address generation adds), a 32-bit limit and a 7-bit attribute word. A single synchronous write port takes one operation per cycle. The operations are: write the selector, the base, the limit or the attributes directly; load base, limit and attributes from a 64-bit data-segment descriptor; or perform a real-mode selector load. A combinational read port returns every field of one entry, zero-extended to 64 bits.

The effective base follows the base on every write, with one exception. For the four legacy data and code segments (indices 0 to 3), it is left untouched while long mode is active. Descriptor loads scale the limit by the granularity bit. A descriptor that is absent, describes a system object or describes a code segment is refused: error flags are raised in the same cycle and no state changes. Instruction decode, descriptor fetch from memory and the memory access itself belong to neighbouring blocks.

Top module: `seg_reg_file`

## Requirements
- R1: After reset every field of every entry is zero, except the limit of the table and task entries (indices 7, 8, 11 and 12), which is 0x0000FFFF.
- R2: Operation code 0 writes wrData[15:0] into the selector of entry wrIdx. rdSel returns the selector zero-extended to 64 bits.
- R3: Operation code 1 writes wrData[63:0] into the base. For entries 4 and above, every base update also writes the same value into the effective base.
- R4: For entries 0 to 3, a base update changes the effective base only while long mode is inactive. Long mode is active when longModeEn is 1 and bit 6 of the attributes of entry 1 is 1.
- R5: Operation code 2 writes wrData[31:0] into the limit, and rdLimit returns it zero-extended. Operation code 3 writes wrData[6:0] into the attributes, laid out as bit 6 long-mode, bit 5 writable, bit 4 readable, bit 3 expand-down, bit 2 default size, bits 1:0 privilege level.
- R6: Operation code 4 (descriptor load) sets the base to {wrData[63:56], wrData[39:16]} zero-extended. It sets the raw 20-bit limit to {wrData[51:48], wrData[15:0]}.
- R7: In a descriptor load with the granularity bit wrData[55] set, the limit becomes the raw limit shifted left by 12 with ones in bits 11:0. With the bit clear, the limit is the raw limit.
- R8: A descriptor load sets the attributes as follows: privilege level from wrData[46:45], default size from wrData[54], expand-down from wrData[42], readable 1, writable from wrData[41], long-mode 0.
- R9: During a descriptor load, errNotPresent is high when wrData[47] is 0, errSystem when wrData[44] is 0, and errCode when wrData[43] is 1. Any raised flag blocks all updates. The flags stay low for every other operation.
- R10: Operation code 5 (real-mode load) writes wrData[15:0] into the selector and sets the base to that value shifted left by 4. The effective base follows the rules of R3 and R4.
- R11: Writes to an index of 13 or above, and operation codes 6 and 7, change nothing. Reads of an index of 13 or above return zero in every field.
- R12: A write takes effect at the rising clock edge. Reads are combinational and show it in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write operation valid this cycle |
| wrOp | input | 3 | Operation code (0 selector, 1 base, 2 limit, 3 attributes, 4 descriptor, 5 real-mode) |
| wrIdx | input | 4 | Entry written |
| wrData | input | 64 | Write value or descriptor |
| longModeEn | input | 1 | Long-mode-active control bit |
| rdIdx | input | 4 | Entry read |
| rdSel | output | 64 | Selector, zero-extended |
| rdBase | output | 64 | Base |
| rdEffBase | output | 64 | Effective base |
| rdLimit | output | 64 | Limit, zero-extended |
| rdAttr | output | 7 | Attributes |
| errNotPresent | output | 1 | Descriptor not present |
| errSystem | output | 1 | Descriptor is a system descriptor |
| errCode | output | 1 | Descriptor is a code segment |

## Verification
A corrupted entry shows up on the read port in the cycle after the faulty write, because reads are combinational. A single read of the affected index therefore exposes a wrong base, limit, attribute or selector. A wrong effective-base decision on a legacy entry is only visible when rdEffBase and rdBase are compared, so those writes are always followed by a read of both. A mis-decoded descriptor error appears on the flags in the same cycle as the load. Any state the refused load failed to protect shows up on the next read of that entry.

// File: rtl/seg_reg_pkg.sv
package seg_reg_pkg;

  localparam int IDX_W      = 4;
  localparam int MAX_SEGS   = 1 << IDX_W;
  localparam int SEL_W      = 16;
  localparam int BASE_W     = 64;
  localparam int LIM_W      = 32;
  localparam int RAW_LIM_W  = 20;
  localparam int DESC_W     = 64;
  localparam int RD_W       = 64;
  localparam int OP_W       = 3;
  localparam int REAL_SHIFT = 4;
  localparam int GRAN_SHIFT = 12;
  localparam int IDX_CS     = 1;

  localparam logic [LIM_W-1:0] TABLE_RESET_LIMIT = 32'h0000_FFFF;

  // Write-port operation codes
  localparam logic [OP_W-1:0] OP_SEL   = 3'd0;
  localparam logic [OP_W-1:0] OP_BASE  = 3'd1;
  localparam logic [OP_W-1:0] OP_LIMIT = 3'd2;
  localparam logic [OP_W-1:0] OP_ATTR  = 3'd3;
  localparam logic [OP_W-1:0] OP_DESC  = 3'd4;
  localparam logic [OP_W-1:0] OP_REAL  = 3'd5;

  typedef struct packed {
    logic       longMode;
    logic       writable;
    logic       readable;
    logic       expandDown;
    logic       defSize;
    logic [1:0] dpl;
  } seg_attr_t;

  localparam int ATTR_W = $bits(seg_attr_t);

  typedef enum logic [1:0] {
    BSRC_RAW  = 2'd0,
    BSRC_DESC = 2'd1,
    BSRC_REAL = 2'd2
  } base_src_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [MAX_SEGS-1:0] hit;
    logic                selWe;
    logic                baseWe;
    logic                effWe;
    logic                limitWe;
    logic                attrWe;
    logic                fromDesc;
    base_src_e           baseSrc;
  } seg_strobe_t;

  // Descriptor classification bits handed back to control
  typedef struct packed {
    logic present;
    logic userSeg;
    logic isCode;
  } desc_class_t;

endpackage

// File: rtl/seg_reg_ctrl.sv
module seg_reg_ctrl
  import seg_reg_pkg::*;
#(
  parameter int NUM_SEGS    = 13,
  parameter int LEGACY_SEGS = 4
) (
  input  logic              wrEn,
  input  logic [OP_W-1:0]   wrOp,
  input  logic [IDX_W-1:0]  wrIdx,
  input  desc_class_t       descClass,
  input  logic              longModeEn,
  input  logic              csLongMode,
  output seg_strobe_t       strobe,
  output logic              errNotPresent,
  output logic              errSystem,
  output logic              errCode
);

  localparam logic [IDX_W:0] SEG_LIMIT_IDX = (IDX_W+1)'(NUM_SEGS);
  localparam logic [IDX_W:0] LEGACY_LIMIT  = (IDX_W+1)'(LEGACY_SEGS);

  logic idxOk;
  logic isLoad;
  logic descBad;
  logic lmActive;
  logic legacy;

  assign idxOk    = {1'b0, wrIdx} < SEG_LIMIT_IDX;
  assign legacy   = {1'b0, wrIdx} < LEGACY_LIMIT;
  assign isLoad   = wrEn && (wrOp == OP_DESC);
  assign lmActive = longModeEn && csLongMode;

  assign errNotPresent = isLoad && !descClass.present;
  assign errSystem     = isLoad && !descClass.userSeg;
  assign errCode       = isLoad && descClass.isCode;
  assign descBad       = errNotPresent || errSystem || errCode;

  always_comb begin
    strobe         = '0;
    strobe.baseSrc = BSRC_RAW;
    if (wrEn && idxOk) begin
      strobe.hit = MAX_SEGS'(1) << wrIdx;
      case (wrOp)
        OP_SEL:   strobe.selWe   = 1'b1;
        OP_BASE:  strobe.baseWe  = 1'b1;
        OP_LIMIT: strobe.limitWe = 1'b1;
        OP_ATTR:  strobe.attrWe  = 1'b1;
        OP_DESC: begin
          if (!descBad) begin
            strobe.baseWe   = 1'b1;
            strobe.limitWe  = 1'b1;
            strobe.attrWe   = 1'b1;
            strobe.fromDesc = 1'b1;
            strobe.baseSrc  = BSRC_DESC;
          end
        end
        OP_REAL: begin
          strobe.selWe   = 1'b1;
          strobe.baseWe  = 1'b1;
          strobe.baseSrc = BSRC_REAL;
        end
        default: ;
      endcase
    end
    // Legacy entries keep their effective base while long mode is on
    strobe.effWe = strobe.baseWe && !(legacy && lmActive);
  end

endmodule

// File: rtl/seg_reg_dp.sv
module seg_reg_dp
  import seg_reg_pkg::*;
#(
  parameter int                  NUM_SEGS         = 13,
  parameter logic [MAX_SEGS-1:0] TABLE_RESET_MASK = 16'h1980
) (
  input  logic                clk,
  input  logic                rstN,
  input  seg_strobe_t         strobe,
  input  logic [DESC_W-1:0]   wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output desc_class_t         descClass,
  output logic                csLongMode,
  output logic [RD_W-1:0]     rdSel,
  output logic [RD_W-1:0]     rdBase,
  output logic [RD_W-1:0]     rdEffBase,
  output logic [RD_W-1:0]     rdLimit,
  output logic [ATTR_W-1:0]   rdAttr
);

  logic [SEL_W-1:0]  selQ  [NUM_SEGS];
  logic [BASE_W-1:0] baseQ [NUM_SEGS];
  logic [BASE_W-1:0] effQ  [NUM_SEGS];
  logic [LIM_W-1:0]  limQ  [NUM_SEGS];
  seg_attr_t         attrQ [NUM_SEGS];

  // Descriptor field extraction
  logic [31:0]          descBase;
  logic [RAW_LIM_W-1:0] rawLim;
  logic [LIM_W-1:0]     descLimit;
  seg_attr_t            descAttr;
  logic                 unusedDesc;

  assign descBase  = {wrData[63:56], wrData[39:16]};
  assign rawLim    = {wrData[51:48], wrData[15:0]};
  assign descLimit = wrData[55] ? {rawLim, {GRAN_SHIFT{1'b1}}}
                                : LIM_W'(rawLim);

  assign descAttr.longMode   = 1'b0;
  assign descAttr.writable   = wrData[41];
  assign descAttr.readable   = 1'b1;
  assign descAttr.expandDown = wrData[42];
  assign descAttr.defSize    = wrData[54];
  assign descAttr.dpl        = wrData[46:45];

  assign descClass.present = wrData[47];
  assign descClass.userSeg = wrData[44];
  assign descClass.isCode  = wrData[43];

  assign unusedDesc = &{1'b0, wrData[53:52], wrData[40]};

  // Values presented to the storage
  logic [SEL_W-1:0]  newSel;
  logic [BASE_W-1:0] newBase;
  logic [LIM_W-1:0]  newLimit;
  seg_attr_t         newAttr;

  assign newSel   = wrData[SEL_W-1:0];
  assign newLimit = strobe.fromDesc ? descLimit : wrData[LIM_W-1:0];
  assign newAttr  = strobe.fromDesc ? descAttr : seg_attr_t'(wrData[ATTR_W-1:0]);

  always_comb begin
    case (strobe.baseSrc)
      BSRC_DESC: newBase = BASE_W'(descBase);
      BSRC_REAL: newBase = BASE_W'({wrData[SEL_W-1:0], {REAL_SHIFT{1'b0}}});
      default:   newBase = wrData[BASE_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEGS; i++) begin
        selQ[i]  <= '0;
        baseQ[i] <= '0;
        effQ[i]  <= '0;
        limQ[i]  <= TABLE_RESET_MASK[i] ? TABLE_RESET_LIMIT : '0;
        attrQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SEGS; i++) begin
        if (strobe.hit[i]) begin
          if (strobe.selWe)   selQ[i]  <= newSel;
          if (strobe.baseWe)  baseQ[i] <= newBase;
          if (strobe.effWe)   effQ[i]  <= newBase;
          if (strobe.limitWe) limQ[i]  <= newLimit;
          if (strobe.attrWe)  attrQ[i] <= newAttr;
        end
      end
    end
  end

  assign csLongMode = attrQ[IDX_CS].longMode;

  always_comb begin
    rdSel     = '0;
    rdBase    = '0;
    rdEffBase = '0;
    rdLimit   = '0;
    rdAttr    = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rdIdx == IDX_W'(i)) begin
        rdSel     = RD_W'(selQ[i]);
        rdBase    = RD_W'(baseQ[i]);
        rdEffBase = RD_W'(effQ[i]);
        rdLimit   = RD_W'(limQ[i]);
        rdAttr    = attrQ[i];
      end
    end
  end

endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_reg_pkg::*;
#(
  parameter int                  NUM_SEGS         = 13,
  parameter int                  LEGACY_SEGS      = 4,
  parameter logic [MAX_SEGS-1:0] TABLE_RESET_MASK = 16'h1980
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [OP_W-1:0]     wrOp,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DESC_W-1:0]   wrData,
  input  logic                longModeEn,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [RD_W-1:0]     rdSel,
  output logic [RD_W-1:0]     rdBase,
  output logic [RD_W-1:0]     rdEffBase,
  output logic [RD_W-1:0]     rdLimit,
  output logic [ATTR_W-1:0]   rdAttr,
  output logic                errNotPresent,
  output logic                errSystem,
  output logic                errCode
);

  seg_strobe_t strobe;
  desc_class_t descClass;
  logic        csLongMode;

  seg_reg_ctrl #(
    .NUM_SEGS   (NUM_SEGS),
    .LEGACY_SEGS(LEGACY_SEGS)
  ) u_ctrl (
    .wrEn         (wrEn),
    .wrOp         (wrOp),
    .wrIdx        (wrIdx),
    .descClass    (descClass),
    .longModeEn   (longModeEn),
    .csLongMode   (csLongMode),
    .strobe       (strobe),
    .errNotPresent(errNotPresent),
    .errSystem    (errSystem),
    .errCode      (errCode)
  );

  seg_reg_dp #(
    .NUM_SEGS        (NUM_SEGS),
    .TABLE_RESET_MASK(TABLE_RESET_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdIdx     (rdIdx),
    .descClass (descClass),
    .csLongMode(csLongMode),
    .rdSel     (rdSel),
    .rdBase    (rdBase),
    .rdEffBase (rdEffBase),
    .rdLimit   (rdLimit),
    .rdAttr    (rdAttr)
  );

endmodule

// File: rtl/seg_reg_file_chk.sv
module seg_reg_file_chk
  import seg_reg_pkg::*;
#(
  parameter int NUM_SEGS    = 13,
  parameter int LEGACY_SEGS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [OP_W-1:0]   wrOp,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DESC_W-1:0] wrData,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [RD_W-1:0]   rdSel,
  input logic [RD_W-1:0]   rdBase,
  input logic [RD_W-1:0]   rdEffBase,
  input logic [RD_W-1:0]   rdLimit,
  input logic [ATTR_W-1:0] rdAttr,
  input logic              errNotPresent,
  input logic              errSystem,
  input logic              errCode
);

  localparam logic [IDX_W:0] SEG_LIMIT_IDX = (IDX_W+1)'(NUM_SEGS);
  localparam logic [IDX_W:0] LEGACY_LIMIT  = (IDX_W+1)'(LEGACY_SEGS);

  logic pastValid;
  logic anyErr;
  logic rdValid;
  logic wrValid;
  logic unusedChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign anyErr    = errNotPresent || errSystem || errCode;
  assign rdValid   = {1'b0, rdIdx} < SEG_LIMIT_IDX;
  assign wrValid   = {1'b0, wrIdx} < SEG_LIMIT_IDX;
  assign unusedChk = &{1'b0, wrData};

  AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel[RD_W-1:SEL_W] == '0) && (rdLimit[RD_W-1:LIM_W] == '0)); // R2

  AST_EFF_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && ({1'b0, rdIdx} >= LEGACY_LIMIT)) |-> (rdEffBase == rdBase)); // R3

  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> (wrEn && (wrOp == OP_DESC))); // R9

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(anyErr) && ($past(wrIdx) == rdIdx) && ($past(rdIdx) == rdIdx))
      |-> ($stable(rdBase) && $stable(rdLimit) && $stable(rdAttr) && $stable(rdSel))); // R9

  AST_REAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && (wrOp == OP_REAL) && wrValid && (wrIdx == rdIdx))
      && ($past(rdIdx) == rdIdx))
      |-> ((rdSel == RD_W'($past(wrData[SEL_W-1:0])))
        && (rdBase == RD_W'({$past(wrData[SEL_W-1:0]), {REAL_SHIFT{1'b0}}})))); // R10

  AST_GRAN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && (wrOp == OP_DESC) && !anyErr && wrData[55] && wrValid
      && (wrIdx == rdIdx)) && ($past(rdIdx) == rdIdx))
      |-> (rdLimit[GRAN_SHIFT-1:0] == {GRAN_SHIFT{1'b1}})); // R7

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> ((rdSel == '0) && (rdBase == '0) && (rdEffBase == '0)
      && (rdLimit == '0) && (rdAttr == '0))); // R11

endmodule

bind seg_reg_file seg_reg_file_chk #(
  .NUM_SEGS   (NUM_SEGS),
  .LEGACY_SEGS(LEGACY_SEGS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrOp         (wrOp),
  .wrIdx        (wrIdx),
  .wrData       (wrData),
  .rdIdx        (rdIdx),
  .rdSel        (rdSel),
  .rdBase       (rdBase),
  .rdEffBase    (rdEffBase),
  .rdLimit      (rdLimit),
  .rdAttr       (rdAttr),
  .errNotPresent(errNotPresent),
  .errSystem    (errSystem),
  .errCode      (errCode)
);

// File: tb/seg_reg_file_bench.sv
module seg_reg_file_bench;

  localparam int NSEG = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrOp = '0;
  logic [3:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        longModeEn = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [63:0] rdSel, rdBase, rdEffBase, rdLimit;
  logic [6:0]  rdAttr;
  logic        errNotPresent, errSystem, errCode;

  seg_reg_file u_seg_reg_file (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOp(wrOp), .wrIdx(wrIdx),
    .wrData(wrData), .longModeEn(longModeEn), .rdIdx(rdIdx),
    .rdSel(rdSel), .rdBase(rdBase), .rdEffBase(rdEffBase),
    .rdLimit(rdLimit), .rdAttr(rdAttr), .errNotPresent(errNotPresent),
    .errSystem(errSystem), .errCode(errCode)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [3:0]  idx;
    logic [63:0] sel;
    logic [63:0] base;
    logic [63:0] eff;
    logic [63:0] limit;
    logic [6:0]  attr;
    int          req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] mSel [16];
  logic [63:0] mBase[16];
  logic [63:0] mEff [16];
  logic [63:0] mLim [16];
  logic [6:0]  mAttr[16];

  task automatic check(int req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected entries and compares the read port
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        rdIdx = e.idx;
        #1;
        check(e.req, "sel",   rdSel,     e.sel);
        check(e.req, "base",  rdBase,    e.base);
        check(e.req, "eff",   rdEffBase, e.eff);
        check(e.req, "limit", rdLimit,   e.limit);
        check(e.req, "attr",  {57'b0, rdAttr}, {57'b0, e.attr});
      end
    end
  end

  task automatic pushExp(logic [3:0] idx, int req);
    exp_t e;
    e.idx = idx; e.sel = mSel[idx]; e.base = mBase[idx]; e.eff = mEff[idx];
    e.limit = mLim[idx]; e.attr = mAttr[idx]; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    #2;
  endtask

  function automatic logic [63:0] mkDesc(logic [31:0] b, logic [19:0] l, bit g, bit d,
                                         logic [1:0] dpl, bit p, bit s, logic [3:0] typ);
    return {b[31:24], g, d, 1'b0, 1'b0, l[19:16], p, dpl, s, typ, b[23:0], l[15:0]};
  endfunction

  // Reference model written from the requirements
  task automatic modelWrite(logic [2:0] op, logic [3:0] idx, logic [63:0] d, bit bad);
    bit lm;
    bit baseW;
    logic [63:0] nb;
    logic [19:0] rl;
    logic [31:0] lim;
    baseW = 1'b0;
    nb = '0;
    if (idx >= NSEG) return;
    lm = longModeEn && mAttr[1][6];
    case (op)
      3'd0: mSel[idx] = {48'b0, d[15:0]};
      3'd1: begin nb = d; baseW = 1'b1; end
      3'd2: mLim[idx] = {32'b0, d[31:0]};
      3'd3: mAttr[idx] = d[6:0];
      3'd4: if (!bad) begin
        nb = {32'b0, d[63:56], d[39:16]};
        baseW = 1'b1;
        rl = {d[51:48], d[15:0]};
        lim = d[55] ? {rl, 12'hFFF} : {12'b0, rl};
        mLim[idx] = {32'b0, lim};
        mAttr[idx] = {1'b0, d[41], 1'b1, d[42], d[54], d[46:45]};
      end
      3'd5: begin
        mSel[idx] = {48'b0, d[15:0]};
        nb = {44'b0, d[15:0], 4'b0};
        baseW = 1'b1;
      end
      default: ;
    endcase
    if (baseW) begin
      mBase[idx] = nb;
      if (!(idx < 4 && lm)) mEff[idx] = nb;
    end
  endtask

  // Driver: applies one write, checks error flags, queues the read-back
  task automatic doWrite(logic [2:0] op, logic [3:0] idx, logic [63:0] d, int req);
    bit ld, enp, es, ec;
    @(negedge clk);
    wrEn = 1'b1; wrOp = op; wrIdx = idx; wrData = d;
    #1;
    ld  = (op == 3'd4);
    enp = ld && !d[47];
    es  = ld && !d[44];
    ec  = ld && d[43];
    check(9, "errNotPresent", {63'b0, errNotPresent}, {63'b0, enp}); // R9
    check(9, "errSystem",     {63'b0, errSystem},     {63'b0, es});  // R9
    check(9, "errCode",       {63'b0, errCode},       {63'b0, ec});  // R9
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    modelWrite(op, idx, d, enp || es || ec);
    pushExp(idx, req);
    drain();
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mSel[i] = '0; mBase[i] = '0; mEff[i] = '0; mAttr[i] = '0;
      mLim[i] = (i == 7 || i == 8 || i == 11 || i == 12) ? 64'h0000_FFFF : '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R11 out-of-range reads
    for (int i = 0; i < 16; i++) pushExp(4'(i), (i < NSEG) ? 1 : 11);
    drain();

    // R2 selector write with upper data bits set
    doWrite(3'd0, 4'd2, 64'hFFFF_FFFF_FFFF_1234, 2);
    // R3 base write on a non-legacy entry
    doWrite(3'd1, 4'd4, 64'h1122_3344_5566_7788, 3);
    // R4 legacy base write with long mode inactive
    doWrite(3'd1, 4'd3, 64'hAAAA_0000_0000_1000, 4);
    // R5 turn on the long-mode attribute of entry 1
    doWrite(3'd3, 4'd1, 64'h0000_0000_0000_0040, 5);
    longModeEn = 1'b1;
    // R4 legacy base write in long mode: effective base kept
    doWrite(3'd1, 4'd3, 64'hBBBB_0000_0000_2000, 4);
    // R3 non-legacy base write in long mode: effective base follows
    doWrite(3'd1, 4'd5, 64'hCCCC_0000_0000_3000, 3);
    // R10 real-mode load into a legacy entry in long mode
    doWrite(3'd5, 4'd0, 64'h0000_0000_0000_F00D, 10);
    longModeEn = 1'b0;
    // R4 legacy base write after long mode drops
    doWrite(3'd1, 4'd3, 64'hDDDD_0000_0000_4000, 4);
    // R5 limit write keeps only 32 bits
    doWrite(3'd2, 4'd6, 64'hFFFF_FFFF_ABCD_0123, 5);
    // R5 attribute write keeps only 7 bits
    doWrite(3'd3, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 5);

    // R6 R8 descriptor load, byte granularity, expand-down writable
    doWrite(3'd4, 4'd2, mkDesc(32'h1234_5678, 20'hABCDE, 0, 1, 2'd3, 1, 1, 4'b0110), 6);
    // R7 page granularity, read-only data
    doWrite(3'd4, 4'd9, mkDesc(32'hFEDC_BA98, 20'h00012, 1, 0, 2'd0, 1, 1, 4'b0001), 7);
    // R7 page granularity with the largest raw limit
    doWrite(3'd4, 4'd10, mkDesc(32'h0000_0000, 20'hFFFFF, 1, 1, 2'd1, 1, 1, 4'b0010), 7);
    // R8 descriptor into a legacy entry
    doWrite(3'd4, 4'd3, mkDesc(32'h8000_0001, 20'h00FFF, 0, 0, 2'd2, 1, 1, 4'b0100), 8);

    // R9 refused loads: not present, system, code, all three
    doWrite(3'd4, 4'd2, mkDesc(32'h5555_5555, 20'h11111, 0, 0, 2'd1, 0, 1, 4'b0010), 9);
    doWrite(3'd4, 4'd2, mkDesc(32'h6666_6666, 20'h22222, 1, 0, 2'd1, 1, 0, 4'b0010), 9);
    doWrite(3'd4, 4'd2, mkDesc(32'h7777_7777, 20'h33333, 0, 1, 2'd0, 1, 1, 4'b1010), 9);
    doWrite(3'd4, 4'd7, mkDesc(32'h9999_9999, 20'h44444, 1, 1, 2'd3, 0, 0, 4'b1000), 9);

    // R10 real-mode load with long mode off
    doWrite(3'd5, 4'd3, 64'hFFFF_FFFF_FFFF_ABCD, 10);

    // R11 writes to an absent entry and unused operation codes
    doWrite(3'd1, 4'd13, 64'h0123_4567_89AB_CDEF, 11);
    doWrite(3'd2, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 11);
    doWrite(3'd6, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 11);
    doWrite(3'd7, 4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 11);
    // R11 no aliasing into real entries
    pushExp(4'd0, 11);
    pushExp(4'd12, 11);
    pushExp(4'd5, 11);
    drain();

    // R12 read in the cycle after a write to the last entry
    doWrite(3'd0, 4'd12, 64'h0000_0000_0000_BEEF, 12);
    // R1 untouched table entry still at its reset limit
    pushExp(4'd8, 1);
    pushExp(4'd11, 1);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule